// File: doc/BRIEF.md
# Codeword Error Statistics Unit

This unit sits behind the correction stage of a Reed-Solomon decoder. For each symbol it takes the value as it arrived from the channel and the value after correction, forwards the corrected symbol unchanged and in order, and derives per-symbol and per-codeword error statistics from the two. Each symbol yields a bit-wise error pattern. Each codeword yields a count of symbols that were changed and a count of bits that were changed. A non-correctable indication from the corrector is carried to the end of the codeword.

Several channels may be interleaved on one stream in a fixed rotation. The unit keeps a separate set of accumulators for every channel, so a codeword's statistics only ever include that channel's own symbols. Bits can be counted as one total or split by the direction of correction (a received 1 fixed to 0, and a received 0 fixed to 1). Each statistic can be left out at build time.

Both sides are valid/ready streams with one output register. A beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no accumulator moves.

Top module: `rs_errstat`

## Requirements
- R1: On every output beat, `out_errval` equals the received symbol XOR the corrected symbol of the matching input beat.
- R2: Every accepted beat appears once on the output, in acceptance order, one cycle after it is taken, with `out_data` equal to the corrected symbol and `out_sop`, `out_eop` and `out_chan` equal to the input markers. Check symbols are forwarded like any other symbol.
- R3: On an end-of-packet beat, `out_nsym` equals the number of beats of that channel's codeword, counted from its start-of-packet beat, whose received and corrected values differ. The count saturates at NCHK/2. On every other beat it is 0.
- R4: In full mode, `out_nbit_tot` on an end-of-packet beat equals the number of differing bits over the channel's codeword, saturating at NCHK/2*SYM_W. `out_nbit_1to0` and `out_nbit_0to1` stay 0. All three are 0 on other beats.
- R5: In split mode, `out_nbit_1to0` counts bits received as 1 and corrected to 0, and `out_nbit_0to1` counts bits received as 0 and corrected to 1. Each saturates at NCHK/2*SYM_W, is reported on the end-of-packet beat and is 0 elsewhere. `out_nbit_tot` stays 0.
- R6: `out_fail` is high on an end-of-packet beat exactly when `in_fail` was high on any beat of that channel's codeword. It is 0 on every other beat.
- R7: Each channel accumulates on its own. Beats of other channels interleaved between a channel's beats do not change its totals, and a start-of-packet beat discards the channel's previous totals.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs keep their values.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: A statistic disabled at build time (error value, symbol count or bit counts) drives 0 on its outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take the input beat |
| in_sop | input | 1 | First symbol of this channel's codeword |
| in_eop | input | 1 | Last symbol of this channel's codeword |
| in_chan | input | CH_W | Channel of the beat |
| in_rx | input | SYM_W | Symbol as received |
| in_fix | input | SYM_W | Symbol after correction |
| in_fail | input | 1 | Corrector found the codeword non-correctable |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_sop | output | 1 | Forwarded start marker |
| out_eop | output | 1 | Forwarded end marker |
| out_chan | output | CH_W | Forwarded channel |
| out_data | output | SYM_W | Corrected symbol |
| out_errval | output | SYM_W | Per-symbol error pattern |
| out_nsym | output | SCW | Symbols changed in the codeword |
| out_nbit_tot | output | BCW | Bits changed, full mode |
| out_nbit_1to0 | output | BCW | Bits fixed from 1 to 0, split mode |
| out_nbit_0to1 | output | BCW | Bits fixed from 0 to 1, split mode |
| out_fail | output | 1 | Codeword non-correctable |

## Verification
Two configurations run side by side on one stream: split counting with every statistic on, and full counting with the error value disabled. Two interleaved channels carry different error patterns: clean symbols, a lone flipped bit every few symbols, every bit inverted, and random masks. The clean and sparse patterns show whether per-channel separation and start-of-packet clearing are right, because a leak between channels or a missed clear shows up as a nonzero or too-large count. Fully inverted codewords drive every count into saturation, and one-symbol codewords put start and end on the same beat. The stream is run once with the consumer always ready and once with random stalls, so a counter that moves on a held beat is caught.

// File: rtl/rs_errstat_pkg.sv
package rs_errstat_pkg;

  typedef enum logic {
    CNT_FULL  = 1'b0,
    CNT_SPLIT = 1'b1
  } bitcnt_e;

  function automatic int sat_cap(input int v, input int cap);
    return (v > cap) ? cap : v;
  endfunction

endpackage

// File: rtl/rs_errstat_diff.sv
module rs_errstat_diff #(
  parameter int SYM_W = 8,
  parameter int PC_W  = 4
) (
  input  logic [SYM_W-1:0] rx,
  input  logic [SYM_W-1:0] fix,
  output logic [SYM_W-1:0] dv,
  output logic             hit,
  output logic [PC_W-1:0]  n10,
  output logic [PC_W-1:0]  n01,
  output logic [PC_W-1:0]  ntot
);

  always_comb begin
    dv   = rx ^ fix;
    hit  = |dv;
    n10  = '0;
    n01  = '0;
    for (int i = 0; i < SYM_W; i++) begin
      n10 = n10 + PC_W'(rx[i] & ~fix[i]);
      n01 = n01 + PC_W'(~rx[i] & fix[i]);
    end
    ntot = n10 + n01;
  end

endmodule

// File: rtl/rs_errstat_lane.sv
module rs_errstat_lane #(
  parameter int SCW  = 4,
  parameter int BCW  = 7,
  parameter int PC_W = 4,
  parameter int SCAP = 8,
  parameter int BCAP = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic            clr,
  input  logic            sym_hit,
  input  logic [PC_W-1:0] add_a,
  input  logic [PC_W-1:0] add_b,
  input  logic            fail_in,
  output logic [SCW-1:0]  nx_sym,
  output logic [BCW-1:0]  nx_a,
  output logic [BCW-1:0]  nx_b,
  output logic            nx_fail
);
  import rs_errstat_pkg::*;

  logic [SCW-1:0] acc_sym;
  logic [BCW-1:0] acc_a, acc_b;
  logic           acc_fail;

  always_comb begin
    int s, a, b;
    s = (clr ? 0 : int'(acc_sym)) + int'(sym_hit);
    a = (clr ? 0 : int'(acc_a)) + int'(add_a);
    b = (clr ? 0 : int'(acc_b)) + int'(add_b);
    nx_sym  = SCW'(sat_cap(s, SCAP));
    nx_a    = BCW'(sat_cap(a, BCAP));
    nx_b    = BCW'(sat_cap(b, BCAP));
    nx_fail = (clr ? 1'b0 : acc_fail) | fail_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_sym  <= '0;
      acc_a    <= '0;
      acc_b    <= '0;
      acc_fail <= 1'b0;
    end else if (hit) begin
      acc_sym  <= nx_sym;
      acc_a    <= nx_a;
      acc_b    <= nx_b;
      acc_fail <= nx_fail;
    end
  end

endmodule

// File: rtl/rs_errstat.sv
module rs_errstat #(
  parameter int SYM_W = 8,
  parameter int NCHK  = 16,
  parameter int NCH   = 2,
  parameter rs_errstat_pkg::bitcnt_e BITMODE = rs_errstat_pkg::CNT_SPLIT,
  parameter bit ERRVAL_EN = 1'b1,
  parameter bit SYMCNT_EN = 1'b1,
  parameter bit BITCNT_EN = 1'b1,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SCAP = NCHK / 2,
  localparam int BCAP = (NCHK / 2) * SYM_W,
  localparam int SCW  = $clog2(SCAP + 1),
  localparam int BCW  = $clog2(BCAP + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sop,
  input  logic             in_eop,
  input  logic [CH_W-1:0]  in_chan,
  input  logic [SYM_W-1:0] in_rx,
  input  logic [SYM_W-1:0] in_fix,
  input  logic             in_fail,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sop,
  output logic             out_eop,
  output logic [CH_W-1:0]  out_chan,
  output logic [SYM_W-1:0] out_data,
  output logic [SYM_W-1:0] out_errval,
  output logic [SCW-1:0]   out_nsym,
  output logic [BCW-1:0]   out_nbit_tot,
  output logic [BCW-1:0]   out_nbit_1to0,
  output logic [BCW-1:0]   out_nbit_0to1,
  output logic             out_fail
);
  import rs_errstat_pkg::*;

  localparam int PC_W = $clog2(SYM_W + 1);
  localparam bit SPLIT = (BITMODE == CNT_SPLIT);

  logic             take;
  logic [SYM_W-1:0] dv;
  logic             sym_hit;
  logic [PC_W-1:0]  n10, n01, ntot, add_a, add_b;

  logic [SCW-1:0] nx_sym  [NCH];
  logic [BCW-1:0] nx_a    [NCH];
  logic [BCW-1:0] nx_b    [NCH];
  logic           nx_fail [NCH];

  logic [SCW-1:0] sel_sym;
  logic [BCW-1:0] sel_a, sel_b;
  logic           sel_fail;

  logic             o_v, o_sop, o_eop, o_fail;
  logic [CH_W-1:0]  o_chan;
  logic [SYM_W-1:0] o_data, o_err;
  logic [SCW-1:0]   o_nsym;
  logic [BCW-1:0]   o_a, o_b;

  assign in_ready = !o_v || out_ready;
  assign take     = in_valid && in_ready;

  rs_errstat_diff #(.SYM_W(SYM_W), .PC_W(PC_W)) u_diff (
    .rx(in_rx), .fix(in_fix), .dv(dv), .hit(sym_hit),
    .n10(n10), .n01(n01), .ntot(ntot)
  );

  generate
    if (SPLIT) begin : g_split
      assign add_a = n10;
      assign add_b = n01;
    end else begin : g_full
      assign add_a = ntot;
      assign add_b = '0;
    end
  endgenerate

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    rs_errstat_lane #(
      .SCW(SCW), .BCW(BCW), .PC_W(PC_W), .SCAP(SCAP), .BCAP(BCAP)
    ) u_lane (
      .clk(clk), .rst_n(rst_n),
      .hit(take && (in_chan == CH_W'(g))),
      .clr(in_sop), .sym_hit(sym_hit),
      .add_a(add_a), .add_b(add_b), .fail_in(in_fail),
      .nx_sym(nx_sym[g]), .nx_a(nx_a[g]), .nx_b(nx_b[g]),
      .nx_fail(nx_fail[g])
    );
  end

  always_comb begin
    sel_sym  = '0;
    sel_a    = '0;
    sel_b    = '0;
    sel_fail = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (in_chan == CH_W'(i)) begin
        sel_sym  = nx_sym[i];
        sel_a    = nx_a[i];
        sel_b    = nx_b[i];
        sel_fail = nx_fail[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_v    <= 1'b0;
      o_sop  <= 1'b0;
      o_eop  <= 1'b0;
      o_chan <= '0;
      o_data <= '0;
      o_err  <= '0;
      o_nsym <= '0;
      o_a    <= '0;
      o_b    <= '0;
      o_fail <= 1'b0;
    end else if (take) begin
      o_v    <= 1'b1;
      o_sop  <= in_sop;
      o_eop  <= in_eop;
      o_chan <= in_chan;
      o_data <= in_fix;
      o_err  <= ERRVAL_EN ? dv : '0;
      o_nsym <= (SYMCNT_EN && in_eop) ? sel_sym : '0;
      o_a    <= (BITCNT_EN && in_eop) ? sel_a : '0;
      o_b    <= (BITCNT_EN && in_eop) ? sel_b : '0;
      o_fail <= in_eop && sel_fail;
    end else if (out_ready) begin
      o_v    <= 1'b0;
    end
  end

  assign out_valid     = o_v;
  assign out_sop       = o_sop;
  assign out_eop       = o_eop;
  assign out_chan      = o_chan;
  assign out_data      = o_data;
  assign out_errval    = o_err;
  assign out_nsym      = o_nsym;
  assign out_fail      = o_fail;
  assign out_nbit_tot  = SPLIT ? '0 : o_a;
  assign out_nbit_1to0 = SPLIT ? o_a : '0;
  assign out_nbit_0to1 = SPLIT ? o_b : '0;

endmodule

// File: rtl/rs_errstat_chk.sv
module rs_errstat_chk #(
  parameter int SYM_W = 8,
  parameter int CH_W  = 1,
  parameter int SCW   = 4,
  parameter int BCW   = 7,
  parameter int SCAP  = 8,
  parameter int BCAP  = 64,
  parameter bit ERRVAL_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [CH_W-1:0]  in_chan,
  input logic [SYM_W-1:0] in_rx,
  input logic [SYM_W-1:0] in_fix,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_eop,
  input logic [CH_W-1:0]  out_chan,
  input logic [SYM_W-1:0] out_data,
  input logic [SYM_W-1:0] out_errval,
  input logic [SCW-1:0]   out_nsym,
  input logic [BCW-1:0]   out_nbit_tot,
  input logic [BCW-1:0]   out_nbit_1to0,
  input logic [BCW-1:0]   out_nbit_0to1,
  input logic             out_fail
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R8: a stalled beat keeps its contents
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed && out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_chan) && $stable(out_eop) && $stable(out_nsym)
      && $stable(out_nbit_1to0) && $stable(out_nbit_0to1));

  // R2: accepted beat appears next cycle carrying the corrected symbol
  a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
    armed && in_valid && in_ready |=> out_valid
      && out_data == $past(in_fix) && out_chan == $past(in_chan));

  generate
    if (ERRVAL_EN) begin : g_ev
      // R1: error pattern of the accepted beat
      a_r1_errval: assert property (@(posedge clk) disable iff (!rst_n)
        armed && in_valid && in_ready |=> out_errval == $past(in_rx ^ in_fix));
    end
  endgenerate

  // R3: statistics are silent away from end-of-packet
  a_r3_quiet_mid: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |-> out_nsym == '0 && out_nbit_tot == '0
      && out_nbit_1to0 == '0 && out_nbit_0to1 == '0);

  // R6: fail only on end-of-packet beats
  a_r6_fail_eop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_fail |-> out_eop);

  // R3: symbol count never passes its cap
  a_r3_sym_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(out_nsym) <= SCAP);

  // R4 / R5: bit counts never pass their cap
  a_r5_bit_cap: assert property (@(posedge clk) disable iff (!rst_n)
    int'(out_nbit_tot) <= BCAP && int'(out_nbit_1to0) <= BCAP
      && int'(out_nbit_0to1) <= BCAP);

endmodule

bind rs_errstat rs_errstat_chk #(
  .SYM_W(SYM_W), .CH_W(CH_W), .SCW(SCW), .BCW(BCW),
  .SCAP(SCAP), .BCAP(BCAP), .ERRVAL_EN(ERRVAL_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_chan(in_chan), .in_rx(in_rx), .in_fix(in_fix),
  .out_valid(out_valid), .out_ready(out_ready), .out_eop(out_eop),
  .out_chan(out_chan), .out_data(out_data), .out_errval(out_errval),
  .out_nsym(out_nsym), .out_nbit_tot(out_nbit_tot),
  .out_nbit_1to0(out_nbit_1to0), .out_nbit_0to1(out_nbit_0to1),
  .out_fail(out_fail)
);

// File: tb/rs_errstat_test.sv
module rs_errstat_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SCAP = 8;
  localparam int BCAP = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_fail = 1'b0;
  logic [0:0] in_chan = '0;
  logic [7:0] in_rx = '0, in_fix = '0;
  logic       out_ready = 1'b0;

  logic       s_ready, s_valid, s_sop, s_eop, s_fail;
  logic [0:0] s_chan;
  logic [7:0] s_data, s_err;
  logic [3:0] s_nsym;
  logic [6:0] s_tot, s_10, s_01;

  logic       f_ready, f_valid, f_sop, f_eop, f_fail;
  logic [0:0] f_chan;
  logic [7:0] f_data, f_err;
  logic [3:0] f_nsym;
  logic [6:0] f_tot, f_10, f_01;

  rs_errstat #(.SYM_W(8), .NCHK(16), .NCH(2),
    .BITMODE(rs_errstat_pkg::CNT_SPLIT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(s_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_chan(in_chan), .in_rx(in_rx),
    .in_fix(in_fix), .in_fail(in_fail), .out_valid(s_valid),
    .out_ready(out_ready), .out_sop(s_sop), .out_eop(s_eop),
    .out_chan(s_chan), .out_data(s_data), .out_errval(s_err),
    .out_nsym(s_nsym), .out_nbit_tot(s_tot), .out_nbit_1to0(s_10),
    .out_nbit_0to1(s_01), .out_fail(s_fail));

  rs_errstat #(.SYM_W(8), .NCHK(16), .NCH(2),
    .BITMODE(rs_errstat_pkg::CNT_FULL), .ERRVAL_EN(1'b0)) uut_full (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(f_ready),
    .in_sop(in_sop), .in_eop(in_eop), .in_chan(in_chan), .in_rx(in_rx),
    .in_fix(in_fix), .in_fail(in_fail), .out_valid(f_valid),
    .out_ready(out_ready), .out_sop(f_sop), .out_eop(f_eop),
    .out_chan(f_chan), .out_data(f_data), .out_errval(f_err),
    .out_nsym(f_nsym), .out_nbit_tot(f_tot), .out_nbit_1to0(f_10),
    .out_nbit_0to1(f_01), .out_fail(f_fail));

  int total = 0;
  int bad   = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: per-channel totals and the expected output beat
  int acc_sym[2], acc_10[2], acc_01[2], acc_tot[2];
  bit acc_fail[2];
  bit e_v = 0, e_sop, e_eop, e_fail;
  int e_chan, e_data, e_err, e_nsym, e_10, e_01, e_tot;

  function automatic int cap(input int v, input int c);
    return (v > c) ? c : v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      e_v = 0;
      for (int c = 0; c < 2; c++) begin
        acc_sym[c] = 0; acc_10[c] = 0; acc_01[c] = 0; acc_tot[c] = 0;
        acc_fail[c] = 0;
      end
    end else if (in_valid && (!e_v || out_ready)) begin
      int c;
      logic [7:0] d;
      c = int'(in_chan);
      d = in_rx ^ in_fix;
      if (in_sop) begin
        acc_sym[c] = 0; acc_10[c] = 0; acc_01[c] = 0; acc_tot[c] = 0;
        acc_fail[c] = 0;
      end
      acc_sym[c] = cap(acc_sym[c] + ((d != 0) ? 1 : 0), SCAP);
      acc_10[c]  = cap(acc_10[c] + $countones(in_rx & ~in_fix), BCAP);
      acc_01[c]  = cap(acc_01[c] + $countones(~in_rx & in_fix), BCAP);
      acc_tot[c] = cap(acc_tot[c] + $countones(d), BCAP);
      acc_fail[c] = acc_fail[c] | in_fail;
      e_v = 1; e_sop = in_sop; e_eop = in_eop; e_chan = c;
      e_data = int'(in_fix); e_err = int'(d);
      e_nsym = in_eop ? acc_sym[c] : 0;
      e_10   = in_eop ? acc_10[c]  : 0;
      e_01   = in_eop ? acc_01[c]  : 0;
      e_tot  = in_eop ? acc_tot[c] : 0;
      e_fail = in_eop && acc_fail[c];
    end else if (out_ready) begin
      e_v = 0;
    end
  end

  bit started = 0;
  always @(negedge clk) begin
    if (rst_n && started) begin
      chk("R2 valid split", s_valid, e_v);
      chk("R2 valid full", f_valid, e_v);
      if (e_v) begin
        chk("R2 data", s_data, e_data);
        chk("R2 sop", s_sop, e_sop);
        chk("R2 eop", s_eop, e_eop);
        chk("R2 chan", s_chan, e_chan);
        chk("R1 errval", s_err, e_err);
        chk("R3 R7 nsym", s_nsym, e_nsym);
        chk("R5 R7 1to0", s_10, e_10);
        chk("R5 R7 0to1", s_01, e_01);
        chk("R5 tot idle in split", s_tot, 0);
        chk("R6 fail", s_fail, e_fail);
        chk("R2 data full", f_data, e_data);
        chk("R10 errval disabled", f_err, 0);
        chk("R3 nsym full", f_nsym, e_nsym);
        chk("R4 R7 tot", f_tot, e_tot);
        chk("R4 split idle in full", int'(f_10) + int'(f_01), 0);
        chk("R6 fail full", f_fail, e_fail);
      end
    end
  end

  typedef struct packed {
    logic       sop, eop;
    logic [0:0] ch;
    logic [7:0] rx, fix;
    logic       fail;
  } beat_t;
  beat_t q[$];

  function automatic logic [7:0] mk_mask(input int pat, input int s);
    case (pat)
      1:       return (s % 5 == 2) ? 8'(1 << ($urandom % 8)) : 8'h00;
      2:       return 8'hFF;
      3:       return 8'($urandom);
      default: return 8'h00;
    endcase
  endfunction

  task automatic add_group(input int n, input int p0, input int p1,
                           input bit f0, input bit f1);
    for (int s = 0; s < n; s++) begin
      for (int c = 0; c < 2; c++) begin
        beat_t b;
        b.sop  = (s == 0);
        b.eop  = (s == n - 1);
        b.ch   = 1'(c);
        b.fix  = 8'($urandom);
        b.rx   = b.fix ^ mk_mask(c ? p1 : p0, s);
        b.fail = (c ? f1 : f0) && (s == n / 2);
        q.push_back(b);
      end
    end
  endtask

  bit stall_mode = 0;
  function automatic logic pick_ready();
    return stall_mode ? logic'(($urandom % 3) != 0) : 1'b1;
  endfunction

  task automatic run_queue();
    while (q.size() > 0) begin
      beat_t b;
      bit acc;
      b = q.pop_front();
      if (($urandom % 4) == 0) begin
        @(negedge clk);
        in_valid  = 1'b0;
        out_ready = pick_ready();
      end
      acc = 0;
      while (!acc) begin
        @(negedge clk);
        out_ready = pick_ready();
        in_valid = 1'b1; in_sop = b.sop; in_eop = b.eop; in_chan = b.ch;
        in_rx = b.rx; in_fix = b.fix; in_fail = b.fail;
        #1;
        chk("R8 ready", s_ready, (!e_v || out_ready));
        chk("R8 ready full", f_ready, (!e_v || out_ready));
        acc = s_ready;
      end
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_stream();
    add_group(6, 0, 1, 1'b0, 1'b0);   // clean beside sparse
    add_group(1, 1, 2, 1'b0, 1'b1);   // one-symbol codewords
    add_group(20, 2, 3, 1'b1, 1'b0);  // saturation and random masks
    add_group(9, 3, 0, 1'b0, 1'b0);   // previous totals must be gone
    add_group(12, 1, 2, 1'b1, 1'b1);
    add_group(4, 0, 0, 1'b0, 1'b0);   // clean after saturated
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 out_valid after reset", s_valid, 0);
    chk("R9 in_ready after reset", s_ready, 1);
    chk("R9 out_valid after reset full", f_valid, 0);
    started = 1;
    load_stream();
    run_queue();
    stall_mode = 1;
    load_stream();
    run_queue();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4ns * 150000);
    bad++;
    total++;
    $display("FAIL watchdog R2 act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule